// File: doc/BRIEF.md
# Next Program Counter Selector

This block works out where a small microcontroller core fetches next. Each cycle it takes the current program counter, a three-bit selection code, and the candidate operands that an instruction may carry: an absolute target, a signed 12-bit branch offset, the 16-bit Z pointer and a 6-bit high-order extension value. From these it forms a 22-bit next address. A single branch-taken input gates every non-sequential choice. When that input is low the core simply falls through to the following word.

The combinational result is presented on `nxt_pc`. It is also captured in a program-counter register that a synchronous reset clears. Decode, fetch and condition evaluation sit outside the block. The core normally feeds `pc_q` back into `cur_pc`, but any value may be presented there.

The selection codes are fixed: 0 sequential, 1 absolute, 2 indirect through Z, 3 extended indirect, 4 relative. The codes 5, 6 and 7 are unused and fall back to sequential. The selector has no internal state of its own. The only register is the program counter, which moves from its reset state (zero) to the computed target on every clock where reset is low.

Top module: `npc_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `pc_q` becomes 0 after that edge.
- R2: While `rst` is low, `pc_q` takes the value `nxt_pc` had just before each rising clock edge.
- R3: When `take` is 0, `nxt_pc` equals `cur_pc + 1` modulo 2^22, whatever `sel_mode` holds.
- R4: When `take` is 1 and `sel_mode` is 1 (absolute), `nxt_pc` equals `jmp_target`.
- R5: When `take` is 1 and `sel_mode` is 2 (indirect), `nxt_pc` is `zptr` zero-extended: bits 21..16 are 0 and bits 15..0 equal `zptr`.
- R6: When `take` is 1 and `sel_mode` is 3 (extended indirect), bits 21..16 of `nxt_pc` equal `ext_hi` and bits 15..0 equal `zptr`.
- R7: When `take` is 1 and `sel_mode` is 4 (relative), `nxt_pc` equals `cur_pc + k + 1` modulo 2^22. Here k is `rel_ofs` read as two's complement, from -2048 (0x800) to 2047 (0x7FF).
- R8: When `take` is 1 and `sel_mode` is 0, 5, 6 or 7, `nxt_pc` equals `cur_pc + 1` modulo 2^22.
- R9: The sequential and relative sums wrap at the 22-bit boundary. `cur_pc` = 0x3FFFFF falling through gives 0, and `cur_pc` = 0 with k = -2048 gives 0x3FF801.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cur_pc | input | 22 | Program counter the next address is computed from |
| sel_mode | input | 3 | Target selection code (0 seq, 1 abs, 2 ind, 3 ext, 4 rel) |
| jmp_target | input | 22 | Absolute target carried by the instruction |
| rel_ofs | input | 12 | Signed branch offset k |
| zptr | input | 16 | Z pointer value |
| ext_hi | input | 6 | High-order extension joined above Z |
| take | input | 1 | Branch taken; low forces fall-through |
| nxt_pc | output | 22 | Combinational next program counter |
| pc_q | output | 22 | Registered program counter |

## Verification
The hardest situations to reach are the arithmetic edges of the relative path. These are the offsets 0x7FF and 0x800, which lie on either side of the sign change, and sums that cross 0x3FFFFF in either direction. Random operands almost never land on them, so the stimulus pins `cur_pc` to 0 and 0x3FFFFF and drives those extreme offsets directly.

Masking by `take` is exercised in the same way. The stimulus presents every non-sequential code with `take` low and operands chosen so that any leak would change the address.

A long random phase follows. It alternates between arbitrary `cur_pc` values and feeding `pc_q` back, which exercises the register path. A behavioural model compares both outputs on every clock.

// File: rtl/npc_pkg.sv
package npc_pkg;

    localparam int NPC_MODE_W = 3;

    typedef enum logic [NPC_MODE_W-1:0] {
        NPC_SEQ = 3'd0,
        NPC_ABS = 3'd1,
        NPC_IND = 3'd2,
        NPC_EXT = 3'd3,
        NPC_REL = 3'd4
    } npc_mode_e;

endpackage

// File: rtl/npc_adders.sv
module npc_adders #(
    parameter int PC_W  = 22,
    parameter int OFS_W = 12
) (
    input  logic [PC_W-1:0]  base_pc,
    input  logic [OFS_W-1:0] ofs,
    output logic [PC_W-1:0]  seq_pc,
    output logic [PC_W-1:0]  rel_pc
);
    localparam int EXT_BITS = PC_W - OFS_W;

    logic [PC_W-1:0] ofs_wide;

    // sign-extend the offset to the PC width
    generate
        if (EXT_BITS > 0) begin : g_sext
            assign ofs_wide = {{EXT_BITS{ofs[OFS_W-1]}}, ofs};
        end else begin : g_trunc
            assign ofs_wide = ofs[PC_W-1:0];
        end
    endgenerate

    always_comb begin
        seq_pc = base_pc + {{(PC_W-1){1'b0}}, 1'b1};
        rel_pc = base_pc + ofs_wide + {{(PC_W-1){1'b0}}, 1'b1};
    end

endmodule

// File: rtl/npc_zjoin.sv
module npc_zjoin #(
    parameter int PC_W = 22,
    parameter int Z_W  = 16
) (
    input  logic [Z_W-1:0]  z_val,
    input  logic [PC_W-Z_W-1:0] hi_val,
    output logic [PC_W-1:0] z_only,
    output logic [PC_W-1:0] z_joined
);
    localparam int HI_W = PC_W - Z_W;

    generate
        if (HI_W > 0) begin : g_join
            assign z_only   = {{HI_W{1'b0}}, z_val};
            assign z_joined = {hi_val, z_val};
        end else begin : g_plain
            assign z_only   = z_val[PC_W-1:0];
            assign z_joined = z_val[PC_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/npc_target_sel.sv
module npc_target_sel
    import npc_pkg::*;
#(
    parameter int PC_W = 22
) (
    input  logic [NPC_MODE_W-1:0] mode_raw,
    input  logic                  taken,
    input  logic [PC_W-1:0]       seq_pc,
    input  logic [PC_W-1:0]       abs_pc,
    input  logic [PC_W-1:0]       ind_pc,
    input  logic [PC_W-1:0]       ext_pc,
    input  logic [PC_W-1:0]       rel_pc,
    output logic [PC_W-1:0]       sel_pc
);
    npc_mode_e mode;

    always_comb begin
        mode = npc_mode_e'(mode_raw);
        if (!taken) begin
            sel_pc = seq_pc;
        end else begin
            unique case (mode)
                NPC_ABS: sel_pc = abs_pc;
                NPC_IND: sel_pc = ind_pc;
                NPC_EXT: sel_pc = ext_pc;
                NPC_REL: sel_pc = rel_pc;
                default: sel_pc = seq_pc;
            endcase
        end
    end

endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter int PC_W  = 22,
    parameter int OFS_W = 12,
    parameter int Z_W   = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [PC_W-1:0]        cur_pc,
    input  logic [NPC_MODE_W-1:0]  sel_mode,
    input  logic [PC_W-1:0]        jmp_target,
    input  logic [OFS_W-1:0]       rel_ofs,
    input  logic [Z_W-1:0]         zptr,
    input  logic [PC_W-Z_W-1:0]    ext_hi,
    input  logic                   take,
    output logic [PC_W-1:0]        nxt_pc,
    output logic [PC_W-1:0]        pc_q
);
    localparam int HI_W = PC_W - Z_W;

    logic [PC_W-1:0] seq_pc;
    logic [PC_W-1:0] rel_pc;
    logic [PC_W-1:0] ind_pc;
    logic [PC_W-1:0] ext_pc;
    logic [PC_W-1:0] sel_pc;

    npc_adders #(.PC_W(PC_W), .OFS_W(OFS_W)) u_add (
        .base_pc (cur_pc),
        .ofs     (rel_ofs),
        .seq_pc  (seq_pc),
        .rel_pc  (rel_pc)
    );

    npc_zjoin #(.PC_W(PC_W), .Z_W(Z_W)) u_zj (
        .z_val    (zptr),
        .hi_val   (ext_hi),
        .z_only   (ind_pc),
        .z_joined (ext_pc)
    );

    npc_target_sel #(.PC_W(PC_W)) u_sel (
        .mode_raw (sel_mode),
        .taken    (take),
        .seq_pc   (seq_pc),
        .abs_pc   (jmp_target),
        .ind_pc   (ind_pc),
        .ext_pc   (ext_pc),
        .rel_pc   (rel_pc),
        .sel_pc   (sel_pc)
    );

    always_comb begin
        nxt_pc = sel_pc;
    end

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= nxt_pc;
    end

    // R2
    pc_follow_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (pc_q == $past(nxt_pc)));

    // R3
    no_take_seq_chk: assert property (@(posedge clk) disable iff (rst)
        !take |-> (nxt_pc == cur_pc + {{(PC_W-1){1'b0}}, 1'b1}));

    // R5
    ind_zero_hi_chk: assert property (@(posedge clk) disable iff (rst)
        (take && sel_mode == NPC_IND) |-> (nxt_pc[PC_W-1:Z_W] == '0 && nxt_pc[Z_W-1:0] == zptr));

    // R6
    ext_join_chk: assert property (@(posedge clk) disable iff (rst)
        (take && sel_mode == NPC_EXT) |-> (nxt_pc[PC_W-1:Z_W] == ext_hi && nxt_pc[Z_W-1:0] == zptr));

    // R4
    abs_target_chk: assert property (@(posedge clk) disable iff (rst)
        (take && sel_mode == NPC_ABS) |-> (nxt_pc == jmp_target));

    // R8
    spare_code_seq_chk: assert property (@(posedge clk) disable iff (rst)
        (take && sel_mode > 3'd4) |-> (nxt_pc == cur_pc + {{(PC_W-1){1'b0}}, 1'b1}));

    initial begin
        assert (HI_W >= 0) else $error("Z width exceeds PC width");
    end

endmodule

// File: tb/npc_unit_bench.sv
`timescale 1ns/1ps
module npc_unit_bench;

    localparam longint MOD = 64'd4194304;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [21:0] cur_pc = '0;
    logic [2:0]  sel_mode = '0;
    logic [21:0] jmp_target = '0;
    logic [11:0] rel_ofs = '0;
    logic [15:0] zptr = '0;
    logic [5:0]  ext_hi = '0;
    logic        take = 1'b0;
    logic [21:0] nxt_pc;
    logic [21:0] pc_q;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    bit have_q = 0;
    bit prev_rst = 0;
    longint exp_q = 0;

    always #4 clk = ~clk;

    npc_unit u_npc_unit (
        .clk(clk), .rst(rst), .cur_pc(cur_pc), .sel_mode(sel_mode),
        .jmp_target(jmp_target), .rel_ofs(rel_ofs), .zptr(zptr),
        .ext_hi(ext_hi), .take(take), .nxt_pc(nxt_pc), .pc_q(pc_q)
    );

    function automatic longint model(longint c, int m, longint t, int o,
                                     longint z, longint e, bit tk);
        longint k;
        if (!tk) return (c + 1) % MOD;
        case (m)
            1: return t;
            2: return z;
            3: return e * 65536 + z;
            4: begin
                k = (o >= 2048) ? o - 4096 : o;
                return ((c + k + 1) % MOD + MOD) % MOD;
            end
            default: return (c + 1) % MOD;
        endcase
    endfunction

    function automatic string tag_of(int m, bit tk);
        if (!tk) return "R3";
        case (m)
            1: return "R4";
            2: return "R5";
            3: return "R6";
            4: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(bit r, logic [21:0] c, logic [2:0] m, logic [21:0] t,
                        logic [11:0] o, logic [15:0] z, logic [5:0] e,
                        bit tk, string req);
        longint en;
        @(negedge clk);
        if (have_q) check(prev_rst ? "R1" : "R2", pc_q, exp_q);
        rst = r; cur_pc = c; sel_mode = m; jmp_target = t;
        rel_ofs = o; zptr = z; ext_hi = e; take = tk;
        #1;
        en = model(c, m, t, o, z, e, tk);
        if (!r) check(req, nxt_pc, en);
        exp_q = r ? 0 : en;
        prev_rst = r;
        have_q = 1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        step(1, 22'h12345, 3'd1, 22'h2AAAA, 12'h0, 16'h0, 6'h0, 1, "R1");
        step(1, 22'h12345, 3'd1, 22'h2AAAA, 12'h0, 16'h0, 6'h0, 1, "R1");
        // R3: take low masks every mode
        for (int m = 0; m < 8; m++)
            step(0, 22'h001000 + 22'(m), 3'(m), 22'h3C0000, 12'h7FF, 16'hBEEF, 6'h2A, 0, "R3");
        // R4
        step(0, 22'h000010, 3'd1, 22'h3ABCDE, 12'h0, 16'h0, 6'h0, 1, "R4");
        // R5
        step(0, 22'h000020, 3'd2, 22'h0, 12'h0, 16'hFFFF, 6'h3F, 1, "R5");
        step(0, 22'h3FFFF0, 3'd2, 22'h0, 12'h0, 16'h0001, 6'h15, 1, "R5");
        // R6
        step(0, 22'h000030, 3'd3, 22'h0, 12'h0, 16'h1234, 6'h3F, 1, "R6");
        step(0, 22'h000030, 3'd3, 22'h0, 12'h0, 16'hFFFF, 6'h01, 1, "R6");
        // R7 offsets at the sign edges
        step(0, 22'h001000, 3'd4, 22'h0, 12'h7FF, 16'h0, 6'h0, 1, "R7");
        step(0, 22'h001000, 3'd4, 22'h0, 12'h800, 16'h0, 6'h0, 1, "R7");
        step(0, 22'h001000, 3'd4, 22'h0, 12'hFFF, 16'h0, 6'h0, 1, "R7");
        // R8 unused codes and code 0
        step(0, 22'h000700, 3'd0, 22'h3FFFFF, 12'h123, 16'h5555, 6'h11, 1, "R8");
        step(0, 22'h000700, 3'd5, 22'h3FFFFF, 12'h123, 16'h5555, 6'h11, 1, "R8");
        step(0, 22'h000700, 3'd6, 22'h3FFFFF, 12'h123, 16'h5555, 6'h11, 1, "R8");
        step(0, 22'h000700, 3'd7, 22'h3FFFFF, 12'h123, 16'h5555, 6'h11, 1, "R8");
        // R9 wraparound
        step(0, 22'h3FFFFF, 3'd0, 22'h0, 12'h0, 16'h0, 6'h0, 1, "R9");
        step(0, 22'h000000, 3'd4, 22'h0, 12'h800, 16'h0, 6'h0, 1, "R9");
        step(0, 22'h3FFFFF, 3'd4, 22'h0, 12'h7FF, 16'h0, 6'h0, 1, "R9");
        step(0, 22'h3FFFFF, 3'd2, 22'h0, 12'h0, 16'h0, 6'h0, 0, "R9");
        // R1 reset in mid-run
        step(1, 22'h3FFFFF, 3'd1, 22'h155555, 12'h0, 16'h0, 6'h0, 1, "R1");
        step(0, 22'h000000, 3'd0, 22'h0, 12'h0, 16'h0, 6'h0, 1, "R8");
        // random phase with closed-loop feedback
        for (int i = 0; i < 400; i++) begin
            logic [21:0] c;
            logic [2:0]  m;
            bit tk;
            m  = 3'($urandom_range(0, 7));
            tk = ($urandom_range(0, 3) != 0);
            c  = (i % 2 == 0 && have_q) ? 22'(exp_q) : 22'($urandom);
            step(($urandom_range(0, 49) == 0), c, m, 22'($urandom), 12'($urandom),
                 16'($urandom), 6'($urandom), tk, tag_of(int'(m), tk));
        end
        @(negedge clk);
        check(prev_rst ? "R1" : "R2", pc_q, exp_q);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule